// File: doc/BRIEF.md
# Event data frame builder

The block turns the stored samples of one acquisition into a fixed sequence of 16-bit words and writes them into a 2048-word memory, one word per clock, ready for a later readout pass. A single start pulse gives the number of filled columns and the chip identifier. The block then fetches each data word it needs from an upstream source over a request/valid handshake. For every column it fetches 64 time samples, then 64 charge samples, each carrying a hit bit and a gain bit. After all columns it fetches one bunch-crossing ID per column. It closes the frame with the chip identifier word.

The source sees which item is wanted from the request kind, column and channel outputs. It answers whenever it can by raising valid with the 12-bit value and the two flags. A low valid stalls the frame with no limit on the wait. A done pulse marks the end of the frame. The total word count is published when the frame starts and holds until the next one starts.

Top module: `event_frame_builder`

## Requirements
- R1: During and after reset, mem_we_o, done_o and req_o are low and word_count_o is zero.
- R2: A sample word holds the 12-bit value in bits 11:0, the gain flag in bit 12 and the hit flag in bit 13, with bits 15:14 zero.
- R3: For column c, the time sample of channel k (request kind 0) is written at address 128c+k, and the charge sample (request kind 1) at 128c+64+k. Columns are written from 0 upward, and the source is asked for that column and channel.
- R4: The bunch-crossing ID of column j (request kind 2) is written at address 128n+j as the 12-bit value zero-extended. The hit and gain inputs are ignored for these words.
- R5: The chip identifier is written last, at address 129n, zero-extended from 8 bits, with no request to the source.
- R6: With n from 1 to 15 filled columns, exactly 129n+1 words are written. word_count_o shows that number from the cycle after the start pulse until the next accepted start.
- R7: A start with zero columns writes nothing, sets word_count_o to 0, and pulses done_o one cycle after the start.
- R8: Each word is written in the cycle after the edge at which req_o and valid_i are both high. No data word is written for a cycle in which valid_i was low.
- R9: done_o is high for exactly one cycle per frame, in the same cycle as the chip identifier write.
- R10: A start pulse that arrives while a frame is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a frame, one cycle |
| col_count_i | input | 4 | Number of filled columns, 0 to 15 |
| chip_id_i | input | 8 | Chip identifier, sampled with start |
| req_o | output | 1 | Data word requested |
| req_kind_o | output | 2 | 0 time, 1 charge, 2 bunch-crossing ID |
| req_col_o | output | 4 | Requested column |
| req_chan_o | output | 6 | Requested channel (0 for bunch-crossing ID) |
| valid_i | input | 1 | Source presents the requested word |
| value_i | input | 12 | Requested value |
| hit_i | input | 1 | Hit flag of the sample |
| gain_i | input | 1 | Gain flag of the sample |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 11 | Memory write address |
| mem_data_o | output | 16 | Memory write data |
| done_o | output | 1 | Frame complete, one cycle |
| word_count_o | output | 11 | Words in the current or last frame |

## Verification
A data word appears on the memory port one clock after the rising edge at which req_o and valid_i were both high. The chip identifier word and done_o appear together one clock after the write of the last bunch-crossing ID. A zero-column start gives done_o one clock after its edge, and word_count_o is updated by that same edge. The bench drives valid at the falling edge and inspects the memory port at the next falling edge. At that point it knows whether the previous cycle held an accepted handshake, so every write, or missing write, is attributed to the exact cycle that caused it.

// File: rtl/ebld_pkg.sv
package ebld_pkg;
  typedef enum logic [1:0] {
    KIND_TIME   = 2'd0,
    KIND_CHARGE = 2'd1,
    KIND_BCID   = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_SAMP = 2'd1,
    PH_BCID = 2'd2,
    PH_CHIP = 2'd3
  } phase_e;
endpackage

// File: rtl/ebld_seq.sv
module ebld_seq #(
  parameter int unsigned CHANNELS = 64,
  parameter int unsigned MAX_COLS = 15,
  parameter int unsigned ADDR_W   = 11,
  localparam int unsigned COL_W   = $clog2(MAX_COLS + 1),
  localparam int unsigned CHAN_W  = $clog2(CHANNELS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  col_count_i,
  input  logic              valid_i,
  output logic              start_ok_o,
  output logic              req_o,
  output logic [1:0]        req_kind_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [CHAN_W-1:0] req_chan_o,
  output logic              wr_o,
  output logic              wr_bcid_o,
  output logic              wr_chip_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              fin_o
);
  import ebld_pkg::*;

  localparam int unsigned SMP_N = 2 * CHANNELS;
  localparam int unsigned SMP_W = $clog2(SMP_N);

  phase_e            phase_q;
  logic [COL_W-1:0]  n_q, col_q;
  logic [SMP_W-1:0]  smp_q;
  logic [ADDR_W-1:0] addr_q;
  logic              accept, last_col, last_smp, charge_half;

  assign accept      = req_o & valid_i;
  assign last_col    = ({1'b0, col_q} + (COL_W+1)'(1)) == {1'b0, n_q};
  assign last_smp    = smp_q == SMP_W'(SMP_N - 1);
  assign charge_half = smp_q >= SMP_W'(CHANNELS);

  assign start_ok_o = (phase_q == PH_IDLE) && start_i;
  assign req_o      = (phase_q == PH_SAMP) || (phase_q == PH_BCID);
  assign req_kind_o = (phase_q == PH_BCID) ? KIND_BCID
                    : (charge_half ? KIND_CHARGE : KIND_TIME);
  assign req_col_o  = col_q;
  assign req_chan_o = charge_half ? CHAN_W'(smp_q - SMP_W'(CHANNELS)) : CHAN_W'(smp_q);

  assign wr_o      = accept || (phase_q == PH_CHIP);
  assign wr_bcid_o = phase_q == PH_BCID;
  assign wr_chip_o = phase_q == PH_CHIP;
  assign wr_addr_o = addr_q;
  // zero-column frames finish straight from idle
  assign fin_o     = (phase_q == PH_CHIP) || (start_ok_o && (col_count_i == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      n_q     <= '0;
      col_q   <= '0;
      smp_q   <= '0;
      addr_q  <= '0;
    end else begin
      if (wr_o) addr_q <= addr_q + ADDR_W'(1);
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          n_q     <= col_count_i;
          col_q   <= '0;
          smp_q   <= '0;
          addr_q  <= '0;
          phase_q <= (col_count_i == '0) ? PH_IDLE : PH_SAMP;
        end
        PH_SAMP: if (accept) begin
          if (last_smp) begin
            smp_q <= '0;
            if (last_col) begin
              col_q   <= '0;
              phase_q <= PH_BCID;
            end else begin
              col_q <= col_q + COL_W'(1);
            end
          end else begin
            smp_q <= smp_q + SMP_W'(1);
          end
        end
        PH_BCID: if (accept) begin
          if (last_col) phase_q <= PH_CHIP;
          else          col_q   <= col_q + COL_W'(1);
        end
        PH_CHIP: phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ebld_hdr.sv
module ebld_hdr #(
  parameter int unsigned CHANNELS = 64,
  parameter int unsigned COL_W    = 4,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned CNT_W    = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_ok_i,
  input  logic [COL_W-1:0] col_count_i,
  input  logic [ID_W-1:0]  chip_id_i,
  output logic [ID_W-1:0]  chip_id_o,
  output logic [CNT_W-1:0] word_count_o
);
  localparam int unsigned COL_WORDS = 2 * CHANNELS + 1;

  logic [CNT_W-1:0] cnt_d;

  // samples and bunch-crossing IDs per column, plus the chip word
  assign cnt_d = (col_count_i == '0) ? '0
               : CNT_W'(col_count_i) * CNT_W'(COL_WORDS) + CNT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_id_o    <= '0;
      word_count_o <= '0;
    end else if (start_ok_i) begin
      chip_id_o    <= chip_id_i;
      word_count_o <= cnt_d;
    end
  end
endmodule

// File: rtl/ebld_pack.sv
module ebld_pack #(
  parameter int unsigned VAL_W  = 12,
  parameter int unsigned ID_W   = 8,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              bcid_i,
  input  logic              chip_i,
  input  logic              fin_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VAL_W-1:0]  value_i,
  input  logic              hit_i,
  input  logic              gain_i,
  input  logic [ID_W-1:0]   chip_id_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              done_o
);
  localparam int unsigned GAIN_B = VAL_W;
  localparam int unsigned HIT_B  = VAL_W + 1;

  logic [WORD_W-1:0] word_d;

  generate
    if (HIT_B >= WORD_W) begin : g_bad_width
      initial $fatal(1, "word too narrow for value and flags");
    end
  endgenerate

  always_comb begin
    word_d = '0;
    if (chip_i) begin
      word_d[ID_W-1:0] = chip_id_i;
    end else begin
      word_d[VAL_W-1:0] = value_i;
      if (!bcid_i) begin
        word_d[GAIN_B] = gain_i;
        word_d[HIT_B]  = hit_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_we_o   <= 1'b0;
      mem_addr_o <= '0;
      mem_data_o <= '0;
      done_o     <= 1'b0;
    end else begin
      mem_we_o <= wr_i;
      done_o   <= fin_i;
      if (wr_i) begin
        mem_addr_o <= addr_i;
        mem_data_o <= word_d;
      end
    end
  end
endmodule

// File: rtl/event_frame_builder.sv
module event_frame_builder #(
  parameter int unsigned CHANNELS = 64,
  parameter int unsigned MAX_COLS = 15,
  parameter int unsigned VAL_W    = 12,
  parameter int unsigned ID_W     = 8,
  parameter int unsigned WORD_W   = 16,
  parameter int unsigned ADDR_W   = 11,
  localparam int unsigned COL_W   = $clog2(MAX_COLS + 1),
  localparam int unsigned CHAN_W  = $clog2(CHANNELS),
  localparam int unsigned CNT_W   = $clog2(MAX_COLS * (2 * CHANNELS + 1) + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  col_count_i,
  input  logic [ID_W-1:0]   chip_id_i,
  output logic              req_o,
  output logic [1:0]        req_kind_o,
  output logic [COL_W-1:0]  req_col_o,
  output logic [CHAN_W-1:0] req_chan_o,
  input  logic              valid_i,
  input  logic [VAL_W-1:0]  value_i,
  input  logic              hit_i,
  input  logic              gain_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [WORD_W-1:0] mem_data_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  word_count_o
);
  logic              start_ok, wr, wr_bcid, wr_chip, fin;
  logic [ADDR_W-1:0] wr_addr;
  logic [ID_W-1:0]   chip_id_q;

  ebld_seq #(
    .CHANNELS(CHANNELS), .MAX_COLS(MAX_COLS), .ADDR_W(ADDR_W)
  ) i_seq (
    .clk_i, .rst_ni, .start_i, .col_count_i, .valid_i,
    .start_ok_o(start_ok), .req_o, .req_kind_o, .req_col_o, .req_chan_o,
    .wr_o(wr), .wr_bcid_o(wr_bcid), .wr_chip_o(wr_chip),
    .wr_addr_o(wr_addr), .fin_o(fin)
  );

  ebld_hdr #(
    .CHANNELS(CHANNELS), .COL_W(COL_W), .ID_W(ID_W), .CNT_W(CNT_W)
  ) i_hdr (
    .clk_i, .rst_ni, .start_ok_i(start_ok), .col_count_i, .chip_id_i,
    .chip_id_o(chip_id_q), .word_count_o
  );

  ebld_pack #(
    .VAL_W(VAL_W), .ID_W(ID_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
  ) i_pack (
    .clk_i, .rst_ni, .wr_i(wr), .bcid_i(wr_bcid), .chip_i(wr_chip), .fin_i(fin),
    .addr_i(wr_addr), .value_i, .hit_i, .gain_i, .chip_id_i(chip_id_q),
    .mem_we_o, .mem_addr_o, .mem_data_o, .done_o
  );
endmodule

// File: rtl/event_frame_builder_chk.sv
module event_frame_builder_chk #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_o,
  input logic              valid_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [WORD_W-1:0] mem_data_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  word_count_o
);
  logic              seen_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (done_o) begin
      seen_q <= 1'b0;
    end else if (mem_we_o) begin
      seen_q <= 1'b1;
      last_q <= mem_addr_o;
    end
  end

  assert_top_bits_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> mem_data_o[WORD_W-1:WORD_W-2] == 2'b00);

  assert_addr_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && seen_q) |-> mem_addr_o == last_q + ADDR_W'(1));

  assert_chip_word_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mem_we_o) |-> mem_data_o[WORD_W-1:8] == '0);

  assert_count_match_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && mem_we_o) |-> word_count_o == CNT_W'(mem_addr_o) + CNT_W'(1));

  assert_stall_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !valid_i) |=> !mem_we_o);

  assert_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind event_frame_builder event_frame_builder_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CNT_W(CNT_W)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_o(req_o), .valid_i(valid_i),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
  .done_o(done_o), .word_count_o(word_count_o)
);

// File: tb/test_event_frame_builder.sv
`timescale 1ns/1ps
module test_event_frame_builder;
  localparam int CH = 64;
  localparam int SPC = 2 * CH;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [3:0]  col_count_i = '0;
  logic [7:0]  chip_id_i = '0;
  logic        req_o;
  logic [1:0]  req_kind_o;
  logic [3:0]  req_col_o;
  logic [5:0]  req_chan_o;
  logic        valid_i = 1'b0;
  logic [11:0] value_i = '0;
  logic        hit_i = 1'b0;
  logic        gain_i = 1'b0;
  logic        mem_we_o;
  logic [10:0] mem_addr_o;
  logic [15:0] mem_data_o;
  logic        done_o;
  logic [10:0] word_count_o;

  int total = 0, bad = 0;
  int cur_n = 0, cur_tag = 0, cur_pct = 100;
  logic [7:0] cur_chip = '0;
  int exp_addr = 0, writes = 0, dones = 0;
  logic running = 1'b0, prev_acc = 1'b0, finished = 1'b0;

  always #5 clk = ~clk;

  event_frame_builder i_event_frame_builder (
    .clk_i(clk), .rst_ni(rst_n), .start_i, .col_count_i, .chip_id_i,
    .req_o, .req_kind_o, .req_col_o, .req_chan_o, .valid_i, .value_i,
    .hit_i, .gain_i, .mem_we_o, .mem_addr_o, .mem_data_o, .done_o, .word_count_o
  );

  function automatic logic [11:0] valf(int kind, int col, int chan, int tag);
    return 12'(tag * 37 + kind * 1000 + col * 131 + chan * 7);
  endfunction
  function automatic logic hitf(int col, int chan, int tag);
    return 1'((col + chan + tag) & 1);
  endfunction
  function automatic logic gainf(int kind, int chan);
    return 1'(((chan >> 1) + kind) & 1);
  endfunction

  function automatic logic [15:0] exp_word(int a, int n, int tag, logic [7:0] chip);
    int col, s, kind, chan;
    if (a < SPC * n) begin
      col = a / SPC; s = a % SPC; kind = (s >= CH) ? 1 : 0; chan = s % CH;
      return {2'b00, hitf(col, chan, tag), gainf(kind, chan), valf(kind, col, chan, tag)};
    end else if (a < (SPC + 1) * n) begin
      return {4'b0000, valf(2, a - SPC * n, 0, tag)};
    end
    return {8'h00, chip};
  endfunction

  function automatic int exp_count(int n);
    return (n == 0) ? 0 : (SPC + 1) * n + 1;
  endfunction

  task automatic check(logic ok, string req, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor, then source model
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (mem_we_o) begin
        writes++;
        check(mem_addr_o == 11'(exp_addr), "R3 address order", int'(mem_addr_o), exp_addr);
        if (exp_addr < SPC * cur_n)
          check(mem_data_o == exp_word(exp_addr, cur_n, cur_tag, cur_chip), "R2/R3 sample word",
                int'(mem_data_o), int'(exp_word(exp_addr, cur_n, cur_tag, cur_chip)));
        else if (exp_addr < (SPC + 1) * cur_n)
          check(mem_data_o == exp_word(exp_addr, cur_n, cur_tag, cur_chip), "R4 bcid word",
                int'(mem_data_o), int'(exp_word(exp_addr, cur_n, cur_tag, cur_chip)));
        else
          check(mem_data_o == exp_word(exp_addr, cur_n, cur_tag, cur_chip), "R5 chip word",
                int'(mem_data_o), int'(exp_word(exp_addr, cur_n, cur_tag, cur_chip)));
        if (exp_addr < (SPC + 1) * cur_n)
          check(prev_acc, "R8 write without handshake", 0, 1);
        exp_addr++;
      end else if (prev_acc) begin
        check(1'b0, "R8 accepted word not written", 0, 1);
      end
      if (done_o) begin
        dones++;
        check(mem_we_o == (cur_n != 0), "R9 done with chip write", int'(mem_we_o), int'(cur_n != 0));
      end
    end
    if (req_o && ($urandom_range(99) < 32'(cur_pct))) begin
      valid_i = 1'b1;
      if (req_kind_o == 2'd2) begin
        value_i = valf(2, int'(req_col_o), 0, cur_tag);
        hit_i = 1'b1; gain_i = 1'b1;
      end else begin
        value_i = valf(int'(req_kind_o), int'(req_col_o), int'(req_chan_o), cur_tag);
        hit_i = hitf(int'(req_col_o), int'(req_chan_o), cur_tag);
        gain_i = gainf(int'(req_kind_o), int'(req_chan_o));
      end
    end else begin
      valid_i = $urandom_range(1) == 1;  // noise outside handshake
      value_i = 12'($urandom);
      hit_i = 1'($urandom); gain_i = 1'($urandom);
      if (req_o) valid_i = 1'b0;
    end
    prev_acc = req_o && valid_i;
  end

  task automatic run_frame(int n, int pct, bit extra_start);
    int guard;
    @(negedge clk);
    cur_n = n; cur_pct = pct; cur_tag = int'($urandom_range(4095));
    cur_chip = 8'($urandom); exp_addr = 0; writes = 0; dones = 0; running = 1'b1;
    start_i = 1'b1; col_count_i = 4'(n); chip_id_i = cur_chip;
    @(negedge clk);
    start_i = 1'b0; chip_id_i = 8'($urandom);
    check(word_count_o == 11'(exp_count(n)), "R6 count after start", int'(word_count_o), exp_count(n));
    guard = 0;
    while (dones == 0 && guard < 20000) begin
      if (extra_start && guard == 40) begin
        start_i = 1'b1; col_count_i = 4'((n % 15) + 1); chip_id_i = ~cur_chip;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
      guard++;
    end
    start_i = 1'b0;
    repeat (4) @(negedge clk);
    check(dones == 1, "R9 one done per frame", dones, 1);
    check(writes == exp_count(n), n == 0 ? "R7 no writes" : "R6 words written", writes, exp_count(n));
    check(word_count_o == 11'(exp_count(n)), "R6 count holds", int'(word_count_o), exp_count(n));
    check(!req_o, "R1 idle no request", int'(req_o), 0);
    if (extra_start)
      check(exp_addr == exp_count(n), "R10 start ignored while busy", exp_addr, exp_count(n));
    running = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(!mem_we_o && !done_o && !req_o && word_count_o == 0, "R1 in reset", int'(mem_we_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!mem_we_o && !done_o && !req_o && word_count_o == 0, "R1 after reset", int'(done_o), 0);
    check(mem_data_o == 16'h0, "R1 data cleared", int'(mem_data_o), 0);
    run_frame(1, 100, 1'b0);   // R3 single column, no stalls
    run_frame(0, 100, 1'b0);   // R7 empty frame
    run_frame(15, 70, 1'b0);   // R6 full memory span
    run_frame(2, 15, 1'b0);    // R8 heavy stalls
    run_frame(3, 60, 1'b1);    // R10 start during frame
    run_frame(1, 100, 1'b0);
    run_frame(0, 50, 1'b0);    // R7 after a frame
    for (int i = 0; i < 5; i++) run_frame(int'($urandom_range(14)) + 1, int'($urandom_range(90)) + 10, 1'b0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule